// File: doc/BRIEF.md
# Pulse-Swallow Divider Chain

This block is the digital divider chain of an integer-N frequency synthesizer. On the feedback side, a prescaler counter divides the oscillator-rate clock by either 32 or 33. A swallow counter picks the modulus. A main counter counts prescaler cycles. Together they give one feedback pulse every 32*B + A oscillator cycles. On the reference side, a separate counter divides the reference clock by R. The phase detector compares the two single-cycle pulse trains.

The divide settings arrive as plain input words. Each divider samples its word only at its own terminal count, so the period in progress always completes at its old length. If a word is outside its legal range, the divider raises an error flag and keeps the setting it already holds. Each side runs in its own clock domain, and the two sides share only the active-low asynchronous reset.

Top module: `pll_div_chain`

## Requirements
- R1: The feedback pulse repeats every 32*B + A cycles of `vco_clk_i`, where B is `main_i` and A is `swallow_i`.
- R2: The ratio stays exact at both ends of the swallow range, A = 0 (N = 32*B) and A = B-1.
- R3: `fb_pulse_o` is high for exactly one `vco_clk_i` cycle per period.
- R4: A feedback setting is legal only when B >= 3 and A < B. An illegal setting drives `fb_err_o` high one `vco_clk_i` cycle after it appears, and the ratio in use does not change. `fb_err_o` returns low one cycle after a legal setting is applied.
- R5: `ref_pulse_o` is high for one `ref_clk_i` cycle every R cycles of `ref_clk_i`, where R is `ref_div_i`, for R from 3 to 63.
- R6: An R below 3 drives `ref_err_o` high one `ref_clk_i` cycle later, and the reference ratio in use does not change.
- R7: A new setting applied in the middle of a period takes effect only after the next pulse. The current period completes at its old length.
- R8: While `rst_ni` is low, all outputs are low. After release, the first feedback pulse comes N `vco_clk_i` cycles later and the first reference pulse comes R `ref_clk_i` cycles later.
- R9: With B = 93, A = 24 and R = 48, the feedback period is 3000 cycles and the reference period is 48 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk_i | input | 1 | Oscillator-rate clock for the feedback divider |
| ref_clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both dividers |
| swallow_i | input | 5 | Swallow count A |
| main_i | input | 8 | Main count B |
| ref_div_i | input | 6 | Reference ratio R |
| fb_pulse_o | output | 1 | One-cycle divided feedback pulse |
| ref_pulse_o | output | 1 | One-cycle divided reference pulse |
| fb_err_o | output | 1 | Feedback setting illegal |
| ref_err_o | output | 1 | Reference setting illegal |

## Verification
The properties assume that each setting word is synchronous to the clock of the divider that reads it. They also assume the word changes no more than once per cycle, so an error flag reflects the word that was sampled at the edge where a load could happen. The bench drives `swallow_i` and `main_i` only on `vco_clk_i` falling edges and `ref_div_i` only on `ref_clk_i` falling edges. Reset is released in the low phase of both clocks. The minimum-gap properties rely on the held setting always being legal, and the stimulus tests that assumption by presenting illegal words while the dividers are running.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned PRE_LOG_DEF = 5;
  localparam int unsigned A_W_DEF     = 5;
  localparam int unsigned B_W_DEF     = 8;
  localparam int unsigned R_W_DEF     = 6;
  localparam int unsigned B_MIN_DEF   = 3;
  localparam int unsigned R_MIN_DEF   = 3;

  function automatic logic in_floor(input int unsigned v, input int unsigned lo);
    return v >= lo;
  endfunction
endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
  parameter int unsigned PRE_LOG = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mod_hi_i,
  output logic tick_o
);
  localparam int unsigned CW = PRE_LOG + 1;
  localparam logic [CW-1:0] LAST_LO = CW'((1 << PRE_LOG) - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(1 << PRE_LOG);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = mod_hi_i ? LAST_HI : LAST_LO;
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/swallow_main_ctl.sv
module swallow_main_ctl
  import pll_div_pkg::*;
#(
  parameter int unsigned A_W   = 5,
  parameter int unsigned B_W   = 8,
  parameter int unsigned B_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           tick_i,
  output logic           run_o,
  output logic           mod_hi_o,
  output logic           pulse_o,
  output logic           err_o,
  output logic [A_W-1:0] act_a_o,
  output logic [B_W-1:0] act_b_o
);
  logic [B_W-1:0] mcnt_q, act_b_q;
  logic [A_W-1:0] act_a_q;
  logic           init_q, err_q;
  logic           legal, term, load;

  assign legal    = in_floor(32'(b_i), B_MIN) && (B_W'(a_i) < b_i);
  assign term     = tick_i && (mcnt_q == act_b_q - 1'b1);
  assign load     = init_q || term;
  // swallow phase: modulus 33 while fewer than A main counts have elapsed
  assign mod_hi_o = mcnt_q < B_W'(act_a_q);
  assign run_o    = !init_q;
  assign pulse_o  = term;
  assign err_o    = err_q;
  assign act_a_o  = act_a_q;
  assign act_b_o  = act_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      err_q   <= 1'b0;
      mcnt_q  <= '0;
      act_a_q <= '0;
      act_b_q <= B_W'(B_MIN);
    end else begin
      init_q <= 1'b0;
      err_q  <= !legal;
      if (term)        mcnt_q <= '0;
      else if (tick_i) mcnt_q <= mcnt_q + 1'b1;
      if (load && legal) begin
        act_a_q <= a_i;
        act_b_q <= b_i;
      end
    end
  end
endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import pll_div_pkg::*;
#(
  parameter int unsigned R_W   = 6,
  parameter int unsigned R_MIN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [R_W-1:0] r_i,
  output logic           pulse_o,
  output logic           err_o,
  output logic [R_W-1:0] act_r_o
);
  logic [R_W-1:0] cnt_q, act_r_q;
  logic           init_q, err_q, legal, term;

  assign legal   = in_floor(32'(r_i), R_MIN);
  assign term    = !init_q && (cnt_q == act_r_q - 1'b1);
  assign pulse_o = term;
  assign err_o   = err_q;
  assign act_r_o = act_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      act_r_q <= R_W'(R_MIN);
    end else begin
      init_q <= 1'b0;
      err_q  <= !legal;
      if (term)         cnt_q <= '0;
      else if (!init_q) cnt_q <= cnt_q + 1'b1;
      if ((init_q || term) && legal) act_r_q <= r_i;
    end
  end
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
  import pll_div_pkg::*;
#(
  parameter int unsigned PRE_LOG = PRE_LOG_DEF,
  parameter int unsigned A_W     = A_W_DEF,
  parameter int unsigned B_W     = B_W_DEF,
  parameter int unsigned R_W     = R_W_DEF,
  parameter int unsigned B_MIN   = B_MIN_DEF,
  parameter int unsigned R_MIN   = R_MIN_DEF
) (
  input  logic           vco_clk_i,
  input  logic           ref_clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] main_i,
  input  logic [R_W-1:0] ref_div_i,
  output logic           fb_pulse_o,
  output logic           ref_pulse_o,
  output logic           fb_err_o,
  output logic           ref_err_o
);
  logic           pre_tick, mod_hi, fb_run;
  logic [A_W-1:0] fb_act_a;
  logic [B_W-1:0] fb_act_b;
  logic [R_W-1:0] ref_act_r;

  dm_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
    .clk_i   (vco_clk_i),
    .rst_ni  (rst_ni),
    .run_i   (fb_run),
    .mod_hi_i(mod_hi),
    .tick_o  (pre_tick)
  );

  swallow_main_ctl #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_ctl (
    .clk_i   (vco_clk_i),
    .rst_ni  (rst_ni),
    .a_i     (swallow_i),
    .b_i     (main_i),
    .tick_i  (pre_tick),
    .run_o   (fb_run),
    .mod_hi_o(mod_hi),
    .pulse_o (fb_pulse_o),
    .err_o   (fb_err_o),
    .act_a_o (fb_act_a),
    .act_b_o (fb_act_b)
  );

  ref_divider #(.R_W(R_W), .R_MIN(R_MIN)) u_ref (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .r_i    (ref_div_i),
    .pulse_o(ref_pulse_o),
    .err_o  (ref_err_o),
    .act_r_o(ref_act_r)
  );
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk #(
  parameter int unsigned PRE_LOG = 5,
  parameter int unsigned A_W     = 5,
  parameter int unsigned B_W     = 8,
  parameter int unsigned R_W     = 6,
  parameter int unsigned B_MIN   = 3,
  parameter int unsigned R_MIN   = 3
) (
  input logic           vco_clk_i,
  input logic           ref_clk_i,
  input logic           rst_ni,
  input logic           fb_pulse_o,
  input logic           ref_pulse_o,
  input logic           fb_err_o,
  input logic           ref_err_o,
  input logic [A_W-1:0] act_a_i,
  input logic [B_W-1:0] act_b_i,
  input logic [R_W-1:0] act_r_i
);
  localparam logic [15:0] FB_MIN_GAP  = 16'((B_MIN << PRE_LOG) - 1);
  localparam logic [15:0] REF_MIN_GAP = 16'(R_MIN - 1);

  logic [15:0] fb_gap, ref_gap;

  always_ff @(posedge vco_clk_i or negedge rst_ni) begin
    if (!rst_ni)             fb_gap <= '0;
    else if (fb_pulse_o)     fb_gap <= '0;
    else if (fb_gap != '1)   fb_gap <= fb_gap + 1'b1;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)             ref_gap <= '0;
    else if (ref_pulse_o)    ref_gap <= '0;
    else if (ref_gap != '1)  ref_gap <= ref_gap + 1'b1;
  end

  AST_FB_ONE_CYCLE: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o); // R3
  AST_FB_ERR_HOLD: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    fb_err_o |-> ($stable(act_a_i) && $stable(act_b_i))); // R4
  AST_FB_ACT_LEGAL: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    (32'(act_b_i) >= B_MIN) && (B_W'(act_a_i) < act_b_i)); // R4
  AST_FB_NO_SHORT: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> (fb_gap >= FB_MIN_GAP)); // R7
  AST_REF_ONE_CYCLE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o); // R5
  AST_REF_ERR_HOLD: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_err_o |-> $stable(act_r_i)); // R6
  AST_REF_NO_SHORT: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> (ref_gap >= REF_MIN_GAP)); // R7
endmodule

bind pll_div_chain pll_div_chain_chk #(
  .PRE_LOG(PRE_LOG), .A_W(A_W), .B_W(B_W), .R_W(R_W), .B_MIN(B_MIN), .R_MIN(R_MIN)
) u_chk (
  .vco_clk_i  (vco_clk_i),
  .ref_clk_i  (ref_clk_i),
  .rst_ni     (rst_ni),
  .fb_pulse_o (fb_pulse_o),
  .ref_pulse_o(ref_pulse_o),
  .fb_err_o   (fb_err_o),
  .ref_err_o  (ref_err_o),
  .act_a_i    (fb_act_a),
  .act_b_i    (fb_act_b),
  .act_r_i    (ref_act_r)
);

// File: tb/pll_div_chain_test.sv
module pll_div_chain_test;
  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_ni  = 1'b0;
  logic [4:0] swallow = 5'd2;
  logic [7:0] main_b  = 8'd5;
  logic [5:0] ref_div = 6'd10;
  logic       fb_pulse, ref_pulse, fb_err, ref_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 vco_clk = ~vco_clk;
  always #6 ref_clk = ~ref_clk;

  pll_div_chain uut (
    .vco_clk_i  (vco_clk),
    .ref_clk_i  (ref_clk),
    .rst_ni     (rst_ni),
    .swallow_i  (swallow),
    .main_i     (main_b),
    .ref_div_i  (ref_div),
    .fb_pulse_o (fb_pulse),
    .ref_pulse_o(ref_pulse),
    .fb_err_o   (fb_err),
    .ref_err_o  (ref_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fb_sync();
    @(negedge vco_clk);
    while (!fb_pulse) @(negedge vco_clk);
  endtask

  task automatic fb_interval(output int n, output bit width_ok);
    n = 0; width_ok = 1'b1;
    do begin
      @(negedge vco_clk); n++;
      if (n == 1 && fb_pulse) width_ok = 1'b0;
    end while (!fb_pulse);
  endtask

  task automatic ref_sync();
    @(negedge ref_clk);
    while (!ref_pulse) @(negedge ref_clk);
  endtask

  task automatic ref_interval(output int n, output bit width_ok);
    n = 0; width_ok = 1'b1;
    do begin
      @(negedge ref_clk); n++;
      if (n == 1 && ref_pulse) width_ok = 1'b0;
    end while (!ref_pulse);
  endtask

  task automatic set_fb(input int a, input int b);
    @(negedge vco_clk);
    swallow = 5'(a);
    main_b  = 8'(b);
  endtask

  task automatic set_ref(input int r);
    @(negedge ref_clk);
    ref_div = 6'(r);
  endtask

  initial begin
    int n_fb, n_ref, n;
    bit wok;
    n_fb = 0; n_ref = 0;
    @(negedge vco_clk);
    // R8 reset state
    chk(!fb_pulse && !ref_pulse && !fb_err && !ref_err, "R8 reset outputs",
        {fb_pulse, ref_pulse, fb_err, ref_err}, 0);
    @(negedge vco_clk);
    rst_ni = 1'b1;
    fork
      begin
        do begin @(negedge vco_clk); n_fb++; end while (!fb_pulse);
      end
      begin
        do begin @(negedge ref_clk); n_ref++; end while (!ref_pulse);
      end
    join
    chk(n_fb == 32*5 + 2, "R8 first fb pulse", n_fb, 32*5 + 2);
    chk(n_ref == 10, "R8 first ref pulse", n_ref, 10);

    // R1 R2 R3 sweep of the feedback ratio over small B, all legal A
    for (int b = 3; b <= 10; b++) begin
      for (int a = 0; a < b; a++) begin
        set_fb(a, b);
        fb_sync();
        fb_interval(n, wok);
        if (a == 0 || a == b - 1) chk(n == 32*b + a, "R2 swallow edge ratio", n, 32*b + a);
        else                      chk(n == 32*b + a, "R1 feedback ratio", n, 32*b + a);
        chk(wok, "R3 fb pulse width", 0, 1);
      end
    end

    // R4 illegal: A equal to B, then B below floor
    set_fb(3, 4);
    fb_sync();
    set_fb(4, 4);
    @(negedge vco_clk);
    chk(fb_err, "R4 err on A>=B", fb_err, 1);
    fb_sync();
    fb_interval(n, wok);
    chk(n == 32*4 + 3, "R4 ratio kept A>=B", n, 32*4 + 3);
    set_fb(0, 2);
    @(negedge vco_clk);
    chk(fb_err, "R4 err on B<3", fb_err, 1);
    fb_sync();
    fb_interval(n, wok);
    chk(n == 32*4 + 3, "R4 ratio kept B<3", n, 32*4 + 3);
    set_fb(1, 3);
    @(negedge vco_clk);
    chk(!fb_err, "R4 err clears", fb_err, 0);

    // R7 change in mid period
    set_fb(2, 6);
    fb_sync();
    fb_interval(n, wok);
    chk(n == 32*6 + 2, "R7 before change", n, 32*6 + 2);
    n = 0;
    repeat (20) begin @(negedge vco_clk); n++; end
    swallow = 5'd7; main_b = 8'd9;
    do begin @(negedge vco_clk); n++; end while (!fb_pulse);
    chk(n == 32*6 + 2, "R7 old period completes", n, 32*6 + 2);
    fb_interval(n, wok);
    chk(n == 32*9 + 7, "R7 new period", n, 32*9 + 7);

    // R5 reference sweep
    for (int r = 3; r <= 20; r++) begin
      set_ref(r);
      ref_sync();
      ref_interval(n, wok);
      chk(n == r, "R5 ref ratio", n, r);
      chk(wok, "R5 ref pulse width", 0, 1);
    end
    set_ref(63);
    ref_sync();
    ref_interval(n, wok);
    chk(n == 63, "R5 ref ratio max", n, 63);

    // R6 illegal R
    set_ref(7);
    ref_sync();
    set_ref(2);
    @(negedge ref_clk);
    chk(ref_err, "R6 err on R=2", ref_err, 1);
    ref_sync();
    ref_interval(n, wok);
    chk(n == 7, "R6 ratio kept R=2", n, 7);
    set_ref(0);
    @(negedge ref_clk);
    chk(ref_err, "R6 err on R=0", ref_err, 1);
    ref_sync();
    ref_interval(n, wok);
    chk(n == 7, "R6 ratio kept R=0", n, 7);

    // R9 worked example
    set_ref(48);
    set_fb(24, 93);
    fork
      begin fb_sync(); fb_interval(n_fb, wok); end
      begin ref_sync(); ref_interval(n_ref, wok); end
    join
    chk(n_fb == 3000, "R9 fb example", n_fb, 3000);
    chk(n_ref == 48, "R9 ref example", n_ref, 48);
    chk(!fb_err && !ref_err, "R9 no error", {fb_err, ref_err}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge vco_clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule